// File: doc/BRIEF.md
# Flit Receiver with CRC Check and Retransmission Request

This block is the receive half of one port of a mesh router. Flits arrive from a neighbouring link one per cycle under a valid/ready handshake. They pass through a two-entry staging buffer and are then assembled into a packet register. A packet is four data flits followed by two check flits. Once all six flits are in, the block computes an 8-bit cyclic redundancy code over the 24 data bits and compares it with the received code.

A matching packet is released to the routing stage and held there until that stage takes it. This is store-and-forward operation: nothing leaves before the check is done. A mismatching packet is dropped, and a one-cycle negative acknowledgement asks the sender to send it again.

While the assembler is busy checking or holding a packet, it stops draining the staging buffer. Once both buffer entries are full, the ready output falls, which stalls the sender without losing any flit.

Top module: `flit_crc_rx`

## Requirements
- R1: During and right after reset, `fl_ready` is 1 and `pkt_valid`, `ack` and `nack` are 0.
- R2: A packet is six 6-bit flits. Flit 0 carries data bits [23:18], flit 1 carries [17:12], flit 2 carries [11:6] and flit 3 carries [5:0]. Flits 4 and 5 form a 12-bit check field, flit 4 being its upper half. The code sits in check-field bits [7:0]. Check-field bits [11:8] are ignored.
- R3: The code is CRC-8 with polynomial 0x07, initial value 0 and no final inversion, fed data bit 23 first. When the received code matches, `ack` is high for exactly one cycle. `pkt_valid` rises in that same cycle, and `pkt_data` then equals the 24 data bits.
- R4: When the received code does not match, `nack` is high for exactly one cycle. The packet is discarded and `pkt_valid` stays 0 for that packet.
- R5: `ack` and `nack` are never high in the same cycle.
- R6: `pkt_valid` rises only together with `ack`. While `pkt_valid` is high and `pkt_take` is low, `pkt_valid` stays high and `pkt_data` stays stable. A `pkt_take` sampled high while `pkt_valid` is high ends the hold at that edge.
- R7: The staging buffer holds two flits. `fl_ready` is 0 exactly while two flits are stored. A flit offered while `fl_ready` is 0 is not taken.
- R8: Across stalls, every accepted flit is used exactly once and in arrival order, so back-to-back packets are delivered intact.
- R9: Suppose the buffer is empty and the assembler is collecting when a packet streams in without gaps. Then the `ack` or `nack` pulse is high in the cycle that starts two clock edges after the edge that accepted the sixth flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fl_valid | input | 1 | Flit offered on `fl_data` |
| fl_data | input | 6 | Incoming flit |
| fl_ready | output | 1 | Staging buffer can take a flit |
| pkt_valid | output | 1 | Checked packet is held for forwarding |
| pkt_data | output | 24 | Data word of the held packet |
| pkt_take | input | 1 | Routing stage consumes the held packet |
| ack | output | 1 | One-cycle pulse: check passed |
| nack | output | 1 | One-cycle pulse: check failed, retransmit |

## Verification
On every cycle, the bound checker enforces several rules. Acknowledge and negative acknowledge never coincide, and each lasts a single cycle. A packet is released only together with an acknowledge and is never shown on a failure. A held packet does not change until it is taken, and the staging buffer neither overflows nor grows while ready is low. What the assertions cannot see is whether the code arithmetic, the flit ordering, the ignored padding bits and the latency are right. The bench shows those through its scenarios: clean packets, a corrupted code, a burst flip in the data, nonzero padding, and a back-to-back pair that forces the sender to stall.

// File: rtl/flit_crc_rx.sv
module flit_crc_rx #(
  parameter int FLIT_W     = 6,
  parameter int DATA_FLITS = 4,
  parameter int CRC_W      = 8,
  parameter logic [CRC_W-1:0] CRC_POLY = 8'h07,
  parameter int BUF_DEPTH  = 2,
  localparam int DATA_W    = FLIT_W * DATA_FLITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fl_valid,
  input  logic [FLIT_W-1:0] fl_data,
  output logic              fl_ready,
  output logic              pkt_valid,
  output logic [DATA_W-1:0] pkt_data,
  input  logic              pkt_take,
  output logic              ack,
  output logic              nack
);
  localparam int CHK_FLITS = (CRC_W + FLIT_W - 1) / FLIT_W;
  localparam int PKT_FLITS = DATA_FLITS + CHK_FLITS;
  localparam int PKT_W     = PKT_FLITS * FLIT_W;
  localparam int IDX_W     = $clog2(PKT_FLITS);
  localparam int CNT_W     = $clog2(BUF_DEPTH + 1);
  localparam int PTR_W     = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;

  typedef enum logic [1:0] {S_COLLECT, S_CHECK, S_HOLD} state_t;

  function automatic logic [CRC_W-1:0] crc_of(input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction

  logic [FLIT_W-1:0] buf_q [BUF_DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic [PKT_W-1:0]  asm_q;
  logic [IDX_W-1:0]  idx_q;
  state_t            state;
  logic              push, pop, crc_ok;

  assign fl_ready  = (count != CNT_W'(BUF_DEPTH));
  assign push      = fl_valid && fl_ready;
  assign pop       = (state == S_COLLECT) && (count != '0);
  assign pkt_valid = (state == S_HOLD);
  assign pkt_data  = asm_q[PKT_W-1 -: DATA_W];
  assign crc_ok    = (crc_of(asm_q[PKT_W-1 -: DATA_W]) == asm_q[CRC_W-1:0]);

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(BUF_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) buf_q[wr_ptr] <= fl_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_COLLECT;
      idx_q <= '0;
      asm_q <= '0;
      ack   <= 1'b0;
      nack  <= 1'b0;
    end else begin
      ack  <= 1'b0;
      nack <= 1'b0;
      case (state)
        S_COLLECT: if (pop) begin
          asm_q <= {asm_q[PKT_W-FLIT_W-1:0], buf_q[rd_ptr]};
          if (idx_q == IDX_W'(PKT_FLITS - 1)) begin
            idx_q <= '0;
            state <= S_CHECK;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_CHECK: begin
          if (crc_ok) begin
            ack   <= 1'b1;
            state <= S_HOLD;
          end else begin
            nack  <= 1'b1;
            state <= S_COLLECT;
          end
        end
        S_HOLD: if (pkt_take) state <= S_COLLECT;
        default: state <= S_COLLECT;
      endcase
    end
  end
endmodule

module flit_crc_rx_chk #(
  parameter int DATA_W    = 24,
  parameter int CNT_W     = 2,
  parameter int BUF_DEPTH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fl_ready,
  input logic              pkt_valid,
  input logic [DATA_W-1:0] pkt_data,
  input logic              pkt_take,
  input logic              ack,
  input logic              nack,
  input logic [CNT_W-1:0]  count
);
  assert_ack_nack_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && nack));
  assert_ack_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_nack_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nack |=> !nack);
  assert_nack_discard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nack |-> !pkt_valid);
  assert_release_with_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_valid) |-> ack);
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_take) |=> (pkt_valid && $stable(pkt_data)));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(BUF_DEPTH));
  assert_no_take_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_ready |=> count <= $past(count));
endmodule

bind flit_crc_rx flit_crc_rx_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .BUF_DEPTH(BUF_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fl_ready(fl_ready), .pkt_valid(pkt_valid),
  .pkt_data(pkt_data), .pkt_take(pkt_take), .ack(ack), .nack(nack),
  .count(count)
);

// File: tb/sim_flit_crc_rx.sv
`timescale 1ns/1ps
module sim_flit_crc_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fl_valid = 1'b0;
  logic [5:0]  fl_data = '0;
  logic        fl_ready;
  logic        pkt_valid;
  logic [23:0] pkt_data;
  logic        pkt_take = 1'b0;
  logic        ack, nack;

  always #4 clk = ~clk;

  flit_crc_rx u0 (
    .clk(clk), .rst_n(rst_n), .fl_valid(fl_valid), .fl_data(fl_data),
    .fl_ready(fl_ready), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .pkt_take(pkt_take), .ack(ack), .nack(nack)
  );

  typedef struct {
    logic [23:0] data;
    bit          ok;
    bit          lat;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  int cyc = 0, last_acc = 0, stall_seen = 0;
  int take_delay = 0, n_ack = 0, n_nack = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [23:0] d);
    logic [8:0] acc;
    acc = '0;
    for (int i = 23; i >= 0; i--) begin
      acc = {acc[7:0], d[i]};
      if (acc[8]) acc = acc ^ 9'h107;
    end
    for (int i = 0; i < 8; i++) begin
      acc = {acc[7:0], 1'b0};
      if (acc[8]) acc = acc ^ 9'h107;
    end
    return acc[7:0];
  endfunction

  task automatic send(input logic [23:0] d, input logic [7:0] c,
                      input logic [3:0] pad, input bit lat);
    exp_t e;
    logic [35:0] words;
    bit got;
    e.data = d; e.ok = (ref_crc(d) == c); e.lat = lat;
    q.push_back(e);
    words = {d, pad, c};
    for (int i = 0; i < 6; i++) begin
      fl_data  = words[35 - 6*i -: 6];
      fl_valid = 1'b1;
      forever begin
        #1 got = fl_ready;
        @(posedge clk);
        if (got) break;
        stall_seen++;
        @(negedge clk);
      end
      #1 last_acc = cyc;
      @(negedge clk);
    end
    fl_valid = 1'b0;
  endtask

  initial begin : monitor
    exp_t e;
    int hold_cnt = 0;
    bit prev_ack = 0, prev_valid = 0, prev_take = 0;
    logic [23:0] prev_data = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (ack && nack) check(0, "R5", "ack and nack together", 1, 0);
      if (prev_ack) check(!ack, "R3", "ack pulse width", ack, 0);
      if (prev_valid && !prev_take && pkt_valid)
        check(pkt_data == prev_data, "R6", "held data stable", pkt_data, prev_data);
      if (ack || nack) begin
        if (q.size() == 0) begin
          check(0, "R8", "unexpected result", ack, 0);
        end else begin
          e = q.pop_front();
          if (e.ok) begin
            check(ack, "R3", "ack on good code", ack, 1);
            check(pkt_valid && pkt_data == e.data, "R3", "released data",
                  pkt_data, e.data);
            n_ack++;
          end else begin
            check(nack, "R4", "nack on bad code", nack, 1);
            check(!pkt_valid, "R4", "bad packet not released", pkt_valid, 0);
            n_nack++;
          end
          if (e.lat) check(cyc == last_acc + 2, "R9", "result latency",
                           cyc - last_acc, 2);
        end
        hold_cnt = take_delay;
      end
      prev_ack = ack; prev_valid = pkt_valid; prev_data = pkt_data;
      if (pkt_valid) begin
        if (hold_cnt == 0) pkt_take = 1'b1;
        else hold_cnt--;
      end else begin
        pkt_take = 1'b0;
      end
      prev_take = pkt_take;
    end
  end

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check(fl_ready == 1 && pkt_valid == 0 && ack == 0 && nack == 0, "R1",
          "outputs in reset", {fl_ready, pkt_valid, ack, nack}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(fl_ready == 1, "R1", "ready after reset", fl_ready, 1);
    check(pkt_valid == 0 && ack == 0 && nack == 0, "R1", "idle after reset",
          {pkt_valid, ack, nack}, 0);

    send(24'hABCDEF, ref_crc(24'hABCDEF), 4'h0, 1);
    repeat (6) @(negedge clk);
    send(24'h000000, ref_crc(24'h000000), 4'h0, 1);
    repeat (6) @(negedge clk);
    // R2: nonzero padding in check field must be ignored
    send(24'hFFFFFF, ref_crc(24'hFFFFFF), 4'hF, 1);
    repeat (6) @(negedge clk);
    // R4: corrupted code, then retransmission
    send(24'h123456, ref_crc(24'h123456) ^ 8'h01, 4'h0, 1);
    repeat (6) @(negedge clk);
    send(24'h123456, ref_crc(24'h123456), 4'h0, 1);
    repeat (6) @(negedge clk);
    // R4: burst of three flipped data bits
    send(24'h654321 ^ 24'h000700, ref_crc(24'h654321), 4'h5, 0);
    repeat (6) @(negedge clk);

    // R7/R8: back-to-back packets with a slow consumer
    take_delay = 15;
    stall_seen = 0;
    send(24'h5A5A5A, ref_crc(24'h5A5A5A), 4'h0, 0);
    send(24'hC3C3C3, ref_crc(24'hC3C3C3), 4'h3, 0);
    check(stall_seen > 0, "R7", "sender stalled on full buffer", stall_seen, 1);

    for (int i = 0; i < 200 && q.size() != 0; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    check(q.size() == 0, "R8", "all packets answered", q.size(), 0);
    check(n_ack == 6, "R3", "ack count", n_ack, 6);
    check(n_nack == 2, "R4", "nack count", n_nack, 2);
    check(pkt_valid == 0 && fl_ready == 1, "R6", "idle at end",
          {pkt_valid, fl_ready}, 2'b01);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule